// File: doc/BRIEF.md
# Quadrature Oscillator Mixer

This block moves a real intermediate-frequency sample stream down to complex baseband. A phase register grows by a programmable tuning word each time a sample is accepted. The upper bits of that phase select a point on a sine wave. The block multiplies each real sample by the cosine at that point to form the in-phase (I) result, and by the sine at the same point to form the quadrature (Q) result. Mixing with the oscillator gives sum and difference frequency terms. The difference term is the baseband component that a later low-pass filter keeps.

The sine table is computed while the design elaborates. It holds a quarter wave, and the rest of the wave comes from mirroring the address and negating the value. Both references come from one phase value and travel through one aligned pipeline, so I and Q always leave together. The package constant `QMIX_CENTER_FCW` gives the tuning word for a 70 MHz centre at a 250 MHz sample clock. An integrator ties it to the tuning port for the usual set-up.

Top module: `qmix_downconv`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `out_valid` is 0. The phase register starts at zero, so the first accepted sample uses table address 0.
- R2: The phase register advances by `fcw` modulo 2^32 on each clock edge where `in_valid` is 1. It holds its value on every other edge.
- R3: The table address is bits 31:22 of the phase register. The lower 22 bits do not affect the outputs.
- R4: For table address p (0..1023), the sine reference is the nearest integer to 32767*sin(2*pi*(p+0.5)/1024). The cosine reference is the nearest integer to 32767*cos(2*pi*(p+0.5)/1024). Both are 16-bit signed.
- R5: `out_i` = floor((x*cos + 16384) / 32768) and `out_q` = floor((x*sin + 16384) / 32768), where x is the 16-bit signed sample. Results are clamped to -32768..32767.
- R6: A sample accepted at clock edge k produces its I and Q with `out_valid` high right after edge k+3. I and Q are on the same cycle, and results come out in the order the samples were accepted.
- R7: A changed `fcw` value takes effect at the edge that accepts a sample. The phase used by the next accepted sample includes it.
- R8: Once `in_valid` has been low for four edges in a row, `out_valid` is 0.
- R9: With `fcw` = `QMIX_CENTER_FCW` (1202590843), the outputs follow R4 and R5 for the phase sequence n*1202590843 mod 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset, released in step with clk |
| in_valid | input | 1 | Sample strobe; high accepts `in_sample` |
| in_sample | input | 16 | Real input sample, signed |
| fcw | input | 32 | Frequency tuning word added per accepted sample |
| out_valid | output | 1 | I/Q results valid |
| out_i | output | 16 | In-phase product, signed |
| out_q | output | 16 | Quadrature product, signed |

## Verification
A phase register that creeps on idle cycles, or drops a tuning step, shifts the table address of every later sample. The bench catches this at the first output after the fault, four cycles on. A wrong table entry or a wrong mirror or sign rule shows only when that address comes up. So the bench sweeps every one of the 1024 addresses at both full-scale sample values, and runs sequences with gaps and changing tuning words. A misaligned pipeline shows as a latency other than four registers, or as I and Q taken from different samples, on the first accepted sample.

// File: rtl/qmix_pkg.sv
package qmix_pkg;
  // Tuning word for a 70 MHz centre at a 250 MHz sample clock: round(0.28 * 2^32)
  localparam logic [31:0] QMIX_CENTER_FCW = 32'd1202590843;
  localparam real QMIX_PI = 3.14159265358979323846;
endpackage

// File: rtl/qmix_phase.sv
module qmix_phase #(
  parameter int PHASE_W = 32,
  parameter int ADDR_W  = 10,
  parameter int DATA_W  = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic signed [DATA_W-1:0] in_sample,
  input  logic [PHASE_W-1:0]       fcw,
  output logic                     s1_valid,
  output logic signed [DATA_W-1:0] s1_sample,
  output logic [ADDR_W-1:0]        s1_addr
);
  logic [PHASE_W-1:0] acc_q, acc_d;

  always_comb begin
    acc_d = acc_q;
    if (in_valid) acc_d = acc_q + fcw;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q    <= '0;
      s1_valid <= 1'b0;
    end else begin
      acc_q    <= acc_d;
      s1_valid <= in_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (in_valid) begin
      s1_sample <= in_sample;
      s1_addr   <= acc_q[PHASE_W-1 -: ADDR_W];
    end
  end

  // R2
  acc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(acc_q));
endmodule

// File: rtl/qmix_sincos_rom.sv
module qmix_sincos_rom #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 16,
  parameter int COEF_W = 16,
  parameter int AMPL   = 32767
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     s1_valid,
  input  logic signed [DATA_W-1:0] s1_sample,
  input  logic [ADDR_W-1:0]        s1_addr,
  output logic                     s2_valid,
  output logic signed [DATA_W-1:0] s2_sample,
  output logic signed [COEF_W-1:0] s2_sin,
  output logic signed [COEF_W-1:0] s2_cos
);
  import qmix_pkg::*;
  localparam int IDX_W  = ADDR_W - 2;
  localparam int QDEPTH = 1 << IDX_W;
  localparam int TOTAL  = 1 << ADDR_W;

  logic [COEF_W-1:0] quarter [QDEPTH];

  for (genvar k = 0; k < QDEPTH; k++) begin : g_quarter
    localparam real ANG = 2.0 * QMIX_PI * (real'(k) + 0.5) / real'(TOTAL);
    assign quarter[k] = COEF_W'($rtoi(real'(AMPL) * $sin(ANG) + 0.5));
  end

  function automatic logic signed [COEF_W-1:0] fold(input logic [ADDR_W-1:0] a);
    logic [IDX_W-1:0]  j;
    logic [COEF_W-1:0] m;
    j = a[ADDR_W-2] ? ~a[IDX_W-1:0] : a[IDX_W-1:0];
    m = quarter[j];
    fold = a[ADDR_W-1] ? -$signed(m) : $signed(m);
  endfunction

  logic [ADDR_W-1:0]        cos_addr;
  logic signed [COEF_W-1:0] sin_d, cos_d;

  always_comb begin
    cos_addr = s1_addr + ADDR_W'(QDEPTH);
    sin_d    = fold(s1_addr);
    cos_d    = fold(cos_addr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) s2_valid <= 1'b0;
    else        s2_valid <= s1_valid;
  end

  always_ff @(posedge clk) begin
    if (s1_valid) begin
      s2_sample <= s1_sample;
      s2_sin    <= sin_d;
      s2_cos    <= cos_d;
    end
  end

  // R4
  sin_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid |=> (s2_sin[COEF_W-1] == $past(s1_addr[ADDR_W-1])));
  // R4
  cos_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid |=> (s2_cos[COEF_W-1] == ($past(s1_addr[ADDR_W-1]) ^ $past(s1_addr[ADDR_W-2]))));
endmodule

// File: rtl/qmix_product.sv
module qmix_product #(
  parameter int DATA_W = 16,
  parameter int COEF_W = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     s2_valid,
  input  logic signed [DATA_W-1:0] s2_sample,
  input  logic signed [COEF_W-1:0] s2_sin,
  input  logic signed [COEF_W-1:0] s2_cos,
  output logic                     out_valid,
  output logic signed [DATA_W-1:0] out_i,
  output logic signed [DATA_W-1:0] out_q
);
  localparam int P_W = DATA_W + COEF_W;
  localparam int SH  = COEF_W - 1;
  localparam logic [P_W:0] HALF = {{(P_W + 1 - SH){1'b0}}, 1'b1, {(SH - 1){1'b0}}};
  localparam logic signed [P_W:0] MAXV = {{(P_W + 2 - DATA_W){1'b0}}, {(DATA_W - 1){1'b1}}};
  localparam logic signed [P_W:0] MINV = ~MAXV;

  function automatic logic signed [DATA_W-1:0] round_sat(input logic signed [P_W-1:0] p);
    logic signed [P_W:0] ext, sum, shr;
    ext = {p[P_W-1], p};
    sum = ext + $signed(HALF);
    shr = sum >>> SH;
    if (shr > MAXV)      round_sat = MAXV[DATA_W-1:0];
    else if (shr < MINV) round_sat = MINV[DATA_W-1:0];
    else                 round_sat = shr[DATA_W-1:0];
  endfunction

  logic                  s3_valid;
  logic signed [P_W-1:0] pi_q, pq_q, pi_d, pq_d;
  logic signed [DATA_W-1:0] oi_d, oq_d;

  always_comb begin
    pi_d = P_W'(s2_sample) * P_W'(s2_cos);
    pq_d = P_W'(s2_sample) * P_W'(s2_sin);
    oi_d = round_sat(pi_q);
    oq_d = round_sat(pq_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s3_valid  <= 1'b0;
      out_valid <= 1'b0;
    end else begin
      s3_valid  <= s2_valid;
      out_valid <= s3_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (s2_valid) begin
      pi_q <= pi_d;
      pq_q <= pq_d;
    end
    if (s3_valid) begin
      out_i <= oi_d;
      out_q <= oq_d;
    end
  end

  // R5
  zero_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s2_valid && s2_sample == '0) |=> (pi_q == '0 && pq_q == '0));
  // R6
  out_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s3_valid |=> out_valid);
  // R8
  out_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !s3_valid |=> !out_valid);
endmodule

// File: rtl/qmix_downconv.sv
module qmix_downconv #(
  parameter int PHASE_W = 32,
  parameter int ADDR_W  = 10,
  parameter int DATA_W  = 16,
  parameter int COEF_W  = 16,
  parameter int AMPL    = 32767
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic signed [DATA_W-1:0] in_sample,
  input  logic [PHASE_W-1:0]       fcw,
  output logic                     out_valid,
  output logic signed [DATA_W-1:0] out_i,
  output logic signed [DATA_W-1:0] out_q
);
  logic                     s1_valid, s2_valid;
  logic signed [DATA_W-1:0] s1_sample, s2_sample;
  logic [ADDR_W-1:0]        s1_addr;
  logic signed [COEF_W-1:0] s2_sin, s2_cos;

  qmix_phase #(.PHASE_W(PHASE_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_phase (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample), .fcw(fcw),
    .s1_valid(s1_valid), .s1_sample(s1_sample), .s1_addr(s1_addr)
  );

  qmix_sincos_rom #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .COEF_W(COEF_W), .AMPL(AMPL)) u_rom (
    .clk(clk), .rst_n(rst_n), .s1_valid(s1_valid), .s1_sample(s1_sample), .s1_addr(s1_addr),
    .s2_valid(s2_valid), .s2_sample(s2_sample), .s2_sin(s2_sin), .s2_cos(s2_cos)
  );

  qmix_product #(.DATA_W(DATA_W), .COEF_W(COEF_W)) u_prod (
    .clk(clk), .rst_n(rst_n), .s2_valid(s2_valid), .s2_sample(s2_sample),
    .s2_sin(s2_sin), .s2_cos(s2_cos),
    .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
  );

  // R1
  rst_quiet_chk: assert property (@(posedge clk) $fell(rst_n) |=> !out_valid);
endmodule

// File: tb/sim_qmix_downconv.sv
module sim_qmix_downconv;
  logic               clk = 1'b0;
  logic               rst_n;
  logic               in_valid;
  logic signed [15:0] in_sample;
  logic [31:0]        fcw;
  logic               out_valid;
  logic signed [15:0] out_i, out_q;

  qmix_downconv u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample), .fcw(fcw),
    .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
  );

  always #10 clk = ~clk;

  typedef struct {
    logic signed [15:0] ei;
    logic signed [15:0] eq;
    int                 cyc;
    string              tag;
  } exp_t;

  exp_t        pend[$];
  int          cyc = 0;
  int          n_chk = 0;
  int          n_bad = 0;
  logic [31:0] macc;
  bit          done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int ref_coef(input int p, input bit want_cos);
    real ang, r, m;
    int  mag;
    ang = 2.0 * 3.14159265358979323846 * (real'(p) + 0.5) / 1024.0;
    r   = 32767.0 * (want_cos ? $cos(ang) : $sin(ang));
    m   = (r < 0.0) ? -r : r;
    mag = $rtoi(m + 0.5);
    return (r < 0.0) ? -mag : mag;
  endfunction

  function automatic int ref_mix(input int x, input int c);
    longint pr, rr;
    pr = longint'(x) * longint'(c);
    rr = (pr + 64'sd16384) >>> 15;
    if (rr > 32767)  rr = 32767;
    if (rr < -32768) rr = -32768;
    return int'(rr);
  endfunction

  task automatic send(input int x, input logic [31:0] f, input string tag);
    exp_t e;
    int   p;
    @(negedge clk);
    in_valid  = 1'b1;
    in_sample = 16'(x);
    fcw       = f;
    p         = int'(macc[31:22]);
    e.ei      = 16'(ref_mix(x, ref_coef(p, 1'b1)));
    e.eq      = 16'(ref_mix(x, ref_coef(p, 1'b0)));
    e.cyc     = cyc;
    e.tag     = tag;
    pend.push_back(e);
    macc      = macc + f;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid  = 1'b0;
      in_sample = 16'sh5a5a;
      fcw       = 32'hdead_beef;
      if (k >= 4) begin
        n_chk++;
        if (out_valid !== 1'b0) begin
          n_bad++;
          $display("FAIL R8 out_valid after idle: actual %b expected 0", out_valid);
        end
      end
    end
  endtask

  // output monitor: R5/R4 values, R6 latency and order
  always @(negedge clk) begin
    if (rst_n && out_valid === 1'b1) begin
      exp_t e;
      if (pend.size() == 0) begin
        n_chk++; n_bad++;
        $display("FAIL R6 unexpected out_valid: actual 1 expected 0");
      end else begin
        e = pend.pop_front();
        n_chk++;
        if (out_i !== e.ei || out_q !== e.eq) begin
          n_bad++;
          $display("FAIL %s I/Q: actual %0d/%0d expected %0d/%0d", e.tag, out_i, out_q, e.ei, e.eq);
        end
        n_chk++;
        if (cyc - e.cyc != 4) begin
          n_bad++;
          $display("FAIL R6 latency: actual %0d expected 4", cyc - e.cyc);
        end
      end
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_sample = '0; fcw = '0; macc = '0;
    repeat (3) @(negedge clk);
    n_chk++;
    if (out_valid !== 1'b0) begin
      n_bad++; $display("FAIL R1 out_valid in reset: actual %b expected 0", out_valid);
    end
    rst_n = 1'b1;
    @(negedge clk);
    n_chk++;
    if (out_valid !== 1'b0) begin
      n_bad++; $display("FAIL R1 out_valid after reset: actual %b expected 0", out_valid);
    end
    // R1: first sample uses address 0
    send(20000, 32'd0, "R1");
    idle(6);
    // R4 R5: full sweep of every table address at both full-scale inputs
    for (int k = 0; k < 1024; k++) send(32767, 32'h0040_0000, "R4");
    for (int k = 0; k < 1024; k++) send(-32768, 32'h0040_0000, "R5");
    idle(6);
    // R3: half-step word, low bits accumulate but must not show
    for (int k = 0; k < 128; k++) send((k * 7919 + 123) % 65536 - 32768, 32'h0020_0001, "R3");
    idle(6);
    // R2: gaps between samples, idle inputs carry junk tuning words
    for (int k = 0; k < 40; k++) begin
      send((k * 4099) % 60000 - 30000, 32'h0123_4567, "R2");
      idle(k % 3);
    end
    idle(6);
    // R7: word changes every sample
    for (int k = 0; k < 200; k++) send((k * 313) % 50000 - 25000, 32'(k * 32'h0111_0011), "R7");
    idle(6);
    // R9: centre frequency word
    for (int k = 0; k < 300; k++)
      send((k * 6151 + 17) % 65536 - 32768, qmix_pkg::QMIX_CENTER_FCW, "R9");
    idle(8);
    n_chk++;
    if (pend.size() != 0) begin
      n_bad++; $display("FAIL R6 missing outputs: actual %0d expected 0", pend.size());
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL R6 watchdog expired: actual hang expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule